// File: doc/BRIEF.md
# Bridge Control Register File

This block holds the 32-bit control words of a system bridge in one memory-mapped window of 28 words, at byte offsets 0x00 through 0x6C. A host reaches it through a plain word-wide register bus that carries an address, a write strobe, write data and registered read data. Every register is also driven out in parallel on a wide image port, so the logic around the block can use the settings directly.

Most words are plain storage. Four words behave differently. The interrupt-enable word can only be changed through a set word and a clear word. The enable word and the interrupt-status word cannot be written by the bus. The status word copies an external status vector on every cycle. The general-configuration word contains a trigger bit: a write that moves this bit from 0 to 1 asks the system for a reset with a one-cycle pulse.

Top module: `bridge_ctrl_regs`

## Requirements
- R1: After reset each word holds its reset value: 0x00=0x00000C40, 0x04=0x00001384, 0x08=0x2BFF8010, 0x0C=0x255E0091, 0x10=0x00006140, 0x1C=0x000001FF, 0x20=0x000001FF, 0x68=0x00000008, 0x6C=0x10000000. Every other word, including the enable word, resets to zero.
- R2: A write to an ordinary word stores the write data at the clock edge of the write. Read data is registered: the word addressed at a clock edge appears on bus_rdata after that edge.
- R3: A write to 0x30 stores the data in 0x30 and ORs it into the enable word at 0x38.
- R4: A write to 0x34 stores the data in 0x34 and clears in the enable word every bit that is 1 in the data.
- R5: Writes to 0x38 (enable) and 0x3C (status) change nothing. The enable word changes only on writes to 0x30 or 0x34.
- R6: The status word at 0x3C takes the value of irq_status_in at every clock edge, so it reads one cycle behind the input.
- R7: A write to 0x04 stores its data. When bit 2 of the stored word was 0 and bit 2 of the new data is 1, sys_reset_req is high for exactly the one cycle after the write edge. In every other case it stays low.
- R8: An address whose two low bits are not zero, or whose word index is 28 or more, is undefined. Writes to it are ignored and reads of it return zero.
- R9: irq_enable equals the enable word. reg_image bits [32k+31:32k] carry the word at byte offset 4k, for k from 0 to 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W (8) | Byte address of the access |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_status_in | input | 32 | External interrupt status, captured every cycle |
| irq_enable | output | 32 | Current interrupt-enable word |
| sys_reset_req | output | 1 | One-cycle system reset request |
| reg_image | output | 896 | All 28 words side by side, word 0 in the low bits |

## Verification
The assertions check on every cycle the rules that hold from one cycle to the next. Set and clear writes must OR into or mask the enable word. No other access may move the enable word. The reset request must last one cycle and may only follow a 0-to-1 write of the trigger bit. An undefined write must leave the image unchanged, an undefined read must return zero, and the status word must track its input. The bench scenarios cover the rest: the exact reset values, readback of each word through the bus, the case where the trigger bit is already 1 after reset and has to be cleared before it can fire, and long random write sequences checked against a model of the whole register file.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    localparam int DATA_W = 32;
    localparam int NREG   = 28;
    localparam int IDX_W  = $clog2(NREG);

    // Word indices whose behaviour differs from plain storage
    localparam int IX_GEN   = 1;   // general configuration, holds the trigger bit
    localparam int IX_ENSET = 12;  // set shadow for the enable word
    localparam int IX_ENCLR = 13;  // clear shadow for the enable word
    localparam int IX_EN    = 14;  // enable word, bus read-only
    localparam int IX_STAT  = 15;  // status word, bus read-only

    localparam int TRIG_BIT = 2;

    typedef enum logic [2:0] {
        K_NONE,
        K_PLAIN,
        K_GEN,
        K_SET,
        K_CLR,
        K_RO
    } wr_kind_e;

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic [DATA_W-1:0] stat;
    } top_state_t;

    function automatic logic [DATA_W-1:0] reset_word(input int unsigned ix);
        case (ix)
            0:       return 32'h0000_0C40;
            1:       return 32'h0000_1384;
            2:       return 32'h2BFF_8010;
            3:       return 32'h255E_0091;
            4:       return 32'h0000_6140;
            7:       return 32'h0000_01FF;
            8:       return 32'h0000_01FF;
            26:      return 32'h0000_0008;
            27:      return 32'h1000_0000;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/bcr_addr_dec.sv
module bcr_addr_dec
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output logic              hit,
    output logic [IDX_W-1:0]  idx,
    output wr_kind_e          kind
);

    localparam int WIDX_W = ADDR_W - 2;
    localparam logic [IDX_W-1:0] C_GEN   = IDX_W'(IX_GEN);
    localparam logic [IDX_W-1:0] C_ENSET = IDX_W'(IX_ENSET);
    localparam logic [IDX_W-1:0] C_ENCLR = IDX_W'(IX_ENCLR);
    localparam logic [IDX_W-1:0] C_EN    = IDX_W'(IX_EN);
    localparam logic [IDX_W-1:0] C_STAT  = IDX_W'(IX_STAT);

    logic [WIDX_W-1:0] widx;

    always_comb begin
        widx = addr[ADDR_W-1:2];
        // misaligned or out-of-window addresses count as undefined (R8)
        hit  = (addr[1:0] == 2'b00) && (widx < WIDX_W'(NREG));
        idx  = widx[IDX_W-1:0];
    end

    always_comb begin
        if (!we || !hit) begin
            kind = K_NONE;
        end else begin
            case (idx)
                C_GEN:          kind = K_GEN;
                C_ENSET:        kind = K_SET;
                C_ENCLR:        kind = K_CLR;
                C_EN, C_STAT:   kind = K_RO;
                default:        kind = K_PLAIN;
            endcase
        end
    end

endmodule

// File: rtl/bcr_irq_mask.sv
module bcr_irq_mask
    import bcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic              clr_we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] en
);

    logic [DATA_W-1:0] en_d, en_q;

    always_comb begin
        en_d = en_q;
        if (set_we) begin
            en_d = en_q | wdata;
        end else if (clr_we) begin
            en_d = en_q & ~wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else begin
            en_q <= en_d;
        end
    end

    assign en = en_q;

endmodule

// File: rtl/bcr_rst_trig.sv
module bcr_rst_trig (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_we,
    input  logic old_bit,
    input  logic new_bit,
    output logic pulse
);

    logic pulse_d, pulse_q;

    always_comb begin
        pulse_d = arm_we && !old_bit && new_bit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= pulse_d;
        end
    end

    assign pulse = pulse_q;

endmodule

// File: rtl/bridge_ctrl_regs.sv
module bridge_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic                   bus_we,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [DATA_W-1:0]      irq_status_in,
    output logic [DATA_W-1:0]      irq_enable,
    output logic                   sys_reset_req,
    output logic [NREG*DATA_W-1:0] reg_image
);

    logic             dec_hit;
    logic [IDX_W-1:0] dec_idx;
    wr_kind_e         dec_kind;
    logic             dec_store;
    logic [DATA_W-1:0] en_w;
    logic [DATA_W-1:0] slot_w [NREG];
    top_state_t       top_d, top_q;

    bcr_addr_dec #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .we   (bus_we),
        .hit  (dec_hit),
        .idx  (dec_idx),
        .kind (dec_kind)
    );

    assign dec_store = (dec_kind != K_NONE) && (dec_kind != K_RO);

    bcr_irq_mask u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (dec_kind == K_SET),
        .clr_we (dec_kind == K_CLR),
        .wdata  (bus_wdata),
        .en     (en_w)
    );

    bcr_rst_trig u_trig (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_we  (dec_kind == K_GEN),
        .old_bit (slot_w[IX_GEN][TRIG_BIT]),
        .new_bit (bus_wdata[TRIG_BIT]),
        .pulse   (sys_reset_req)
    );

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        if (i == IX_EN) begin : g_en
            assign slot_w[i] = en_w;
        end else if (i == IX_STAT) begin : g_stat
            assign slot_w[i] = top_q.stat;
        end else begin : g_rw
            logic [DATA_W-1:0] val_d, val_q;

            always_comb begin
                val_d = val_q;
                if (dec_store && (dec_idx == IDX_W'(i))) begin
                    val_d = bus_wdata;
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    val_q <= reset_word(i);
                end else begin
                    val_q <= val_d;
                end
            end

            assign slot_w[i] = val_q;
        end
        assign reg_image[i*DATA_W +: DATA_W] = slot_w[i];
    end

    always_comb begin
        top_d      = top_q;
        top_d.stat = irq_status_in;
        top_d.rdata = dec_hit ? slot_w[dec_idx] : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            top_q <= '0;
        end else begin
            top_q <= top_d;
        end
    end

    assign bus_rdata  = top_q.rdata;
    assign irq_enable = en_w;

endmodule

// File: rtl/bcr_chk.sv
module bcr_chk
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic                   bus_we,
    input logic [DATA_W-1:0]      bus_wdata,
    input logic [DATA_W-1:0]      bus_rdata,
    input logic [DATA_W-1:0]      irq_status_in,
    input logic [DATA_W-1:0]      irq_enable,
    input logic                   sys_reset_req,
    input logic [NREG*DATA_W-1:0] reg_image
);

    logic                   addr_ok;
    logic [ADDR_W-3:0]      word;
    logic [NREG*DATA_W-1:0] img_nostat;

    always_comb begin
        word       = bus_addr[ADDR_W-1:2];
        addr_ok    = (bus_addr[1:0] == 2'b00) && (word < (ADDR_W-2)'(NREG));
        img_nostat = reg_image;
        img_nostat[IX_STAT*DATA_W +: DATA_W] = '0;
    end

    a_r3_set_or: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_ok && word == (ADDR_W-2)'(IX_ENSET))
        |=> irq_enable == ($past(irq_enable) | $past(bus_wdata)));

    a_r4_clr_mask: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && addr_ok && word == (ADDR_W-2)'(IX_ENCLR))
        |=> irq_enable == ($past(irq_enable) & ~$past(bus_wdata)));

    a_r5_en_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && addr_ok && (word == (ADDR_W-2)'(IX_ENSET) || word == (ADDR_W-2)'(IX_ENCLR)))
        |=> $stable(irq_enable));

    a_r6_stat_track: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> reg_image[IX_STAT*DATA_W +: DATA_W] == $past(irq_status_in));

    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |=> !sys_reset_req);

    a_r7_cause: assert property (@(posedge clk) disable iff (!rst_n)
        sys_reset_req |-> $past(bus_we && addr_ok && word == (ADDR_W-2)'(IX_GEN)
                                && bus_wdata[TRIG_BIT]
                                && !reg_image[IX_GEN*DATA_W + TRIG_BIT]));

    a_r8_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && !addr_ok) |=> $stable(img_nostat));

    a_r8_rd_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_ok |=> bus_rdata == '0);

endmodule

bind bridge_ctrl_regs bcr_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_bridge_ctrl_regs.sv
`timescale 1ns/1ps
module sim_bridge_ctrl_regs;

    localparam int NR = 28;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [31:0]   irq_status_in = '0;
    logic [31:0]   irq_enable;
    logic          sys_reset_req;
    logic [NR*32-1:0] reg_image;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    logic [31:0] m_reg [NR];
    logic [31:0] m_en;

    always #2 clk = ~clk;

    bridge_ctrl_regs u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_status_in(irq_status_in),
        .irq_enable(irq_enable), .sys_reset_req(sys_reset_req), .reg_image(reg_image)
    );

    function automatic logic [31:0] init_val(input int k);
        logic [31:0] v;
        v = 32'h0;
        if (k == 0)  v = 32'h0000_0C40;
        if (k == 1)  v = 32'h0000_1384;
        if (k == 2)  v = 32'h2BFF_8010;
        if (k == 3)  v = 32'h255E_0091;
        if (k == 4)  v = 32'h0000_6140;
        if (k == 7 || k == 8) v = 32'h0000_01FF;
        if (k == 26) v = 32'h0000_0008;
        if (k == 27) v = 32'h1000_0000;
        return v;
    endfunction

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got %h exp %h", tag, got, exp);
        end
    endtask

    task automatic chk_img(input string tag);
        for (int k = 0; k < NR; k++) begin
            if (k == 15) continue;
            chk(tag, reg_image[k*32 +: 32], (k == 14) ? m_en : m_reg[k]);
        end
        chk("R9 irq_enable port", irq_enable, m_en);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        int  ix;
        bit  ok;
        bit  exp_p;
        ix    = int'(a[7:2]);
        ok    = (a[1:0] == 2'b00) && (ix < NR);
        exp_p = ok && ix == 1 && !m_reg[1][2] && d[2];
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (ok && ix != 14 && ix != 15) m_reg[ix] = d;
        if (ok && ix == 12) m_en = m_en | d;
        if (ok && ix == 13) m_en = m_en & ~d;
        chk("R7 reset request after write", {31'b0, sys_reset_req}, {31'b0, exp_p});
        chk_img("R2 R3 R4 R5 R8 image after write");
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b0;
        @(negedge clk);
        chk(tag, bus_rdata, exp);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int unsigned seed_use;
        seed_use = $urandom(32'h5EED_0042);
        for (int k = 0; k < NR; k++) m_reg[k] = init_val(k);
        m_en = '0;

        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state on the image and the bus
        chk_img("R1 reset value");
        chk("R7 no request after reset", {31'b0, sys_reset_req}, 32'h0);
        for (int k = 0; k < NR; k++) begin
            if (k == 15) continue;
            rd(8'(k*4), (k == 14) ? 32'h0 : init_val(k), "R1 R2 reset readback");
        end

        // R7: trigger bit already 1 after reset, no pulse; clear, then set fires once
        wr(8'h04, 32'h0000_1384);
        wr(8'h04, 32'h0000_1380);
        wr(8'h04, 32'h0000_1384);
        @(negedge clk);
        chk("R7 pulse lasts one cycle", {31'b0, sys_reset_req}, 32'h0);
        wr(8'h04, 32'h0000_0000);
        wr(8'h04, 32'h0000_0003);

        // R3 / R4: set and clear shadows
        wr(8'h30, 32'h0000_00F0);
        wr(8'h30, 32'h0000_0F00);
        wr(8'h34, 32'h0000_0030);
        rd(8'h30, 32'h0000_0F00, "R3 set shadow readback");
        rd(8'h34, 32'h0000_0030, "R4 clear shadow readback");
        rd(8'h38, 32'h0000_0FC0, "R3 R4 enable readback");

        // R5: read-only words
        irq_status_in = 32'hA5A5_3C3C;
        wr(8'h38, 32'hFFFF_FFFF);
        wr(8'h3C, 32'h0000_0000);
        rd(8'h38, 32'h0000_0FC0, "R5 enable ignores write");
        rd(8'h3C, 32'hA5A5_3C3C, "R5 R6 status ignores write");

        // R6: status follows the input
        irq_status_in = 32'h1234_8765;
        @(negedge clk);
        chk("R6 status in image", reg_image[15*32 +: 32], 32'h1234_8765);
        rd(8'h3C, 32'h1234_8765, "R6 status readback");

        // R8: undefined addresses
        wr(8'h70, 32'hDEAD_BEEF);
        wr(8'hFC, 32'hDEAD_BEEF);
        wr(8'h09, 32'hDEAD_BEEF);
        wr(8'h06, 32'hFFFF_FFFF);
        rd(8'h70, 32'h0, "R8 read beyond window");
        rd(8'h0A, 32'h0, "R8 misaligned read");
        rd(8'h08, m_reg[2], "R8 aligned neighbour intact");

        // random mix checked against the model
        for (int n = 0; n < 400; n++) begin
            logic [7:0] a;
            if ($urandom_range(0, 7) == 0) a = 8'($urandom_range(0, 255));
            else a = 8'($urandom_range(0, 31) * 4);
            wr(a, $urandom());
        end
        for (int k = 0; k < NR; k++) begin
            if (k == 15) continue;
            rd(8'(k*4), (k == 14) ? m_en : m_reg[k], "R2 R9 final readback");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule